// File: doc/BRIEF.md
# Pixel Data Frame Builder

The builder turns one readout of a pixel sensor, a 256-bit hit word plus a 14-bit timestamp, into a fixed 320-bit transmit frame. It then emits that frame as ten 32-bit words on consecutive cycles, ready for a serializer. The frame is laid out as follows:

- a constant 10-bit sync header;
- the 270-bit payload, made of the pixel word and then the timestamp, both whitened by an additive scrambler;
- a 40-bit parity field produced by an external Reed-Solomon encoder.

The builder presents the scrambled payload to that encoder and reads the parity back while the last two words go out.

The scrambler is a 7-bit LFSR with the polynomial x^7+x^6+1. Its state is kept in three copies behind a bitwise majority vote. Every cycle, each copy is rewritten with the voted value, so a single upset is outvoted at once and repaired on the next clock edge. The keystream runs on from frame to frame and restarts from its seed only at reset.

The input follows valid/ready rules. Upstream raises `in_valid` and holds its data stable until it sees `in_ready` high at a clock edge. While a frame is being sent, `in_ready` stays low, which holds back the next input. The output has no back-pressure: a serializer cannot stall, so `out_valid` marks ten unbroken word cycles.

Top module: `pixel_frame_builder`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: Each accepted input produces exactly ten words with `out_valid` high on ten consecutive cycles, the first word in the cycle right after the accepting clock edge.
- R3: The top 10 bits of the first word of each frame are 10'b1111100000.
- R4: The frame is {header, payload, parity} sent most significant word first. The payload is {in_pixels, in_tstamp} XOR keystream, with the first keystream bit applied to payload bit 269 and later bits moving toward bit 0.
- R5: Keystream bit k = s[6]^s[5], and the state then becomes {s[5:0], k}. The state is 7'h7F after reset and advances 270 steps per accepted frame without reseeding.
- R6: `enc_data` carries the scrambled payload and stays stable for the whole frame. `enc_parity[39:32]` fills the low 8 bits of word 8 and `enc_parity[31:0]` is word 9.
- R7: `in_ready` is low during words 0 to 8 of a frame, so an input offered then is held and the frame is never cut short. It is high on word 9 and when idle.
- R8: An input accepted on word 9 starts its frame on the next cycle, with no idle cycle between the frames.
- R9: Corrupting any one copy of the scrambler state does not change the output, and that copy is restored by the vote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input data offered |
| in_ready | output | 1 | Builder can take an input this cycle |
| in_pixels | input | 256 | Pixel hit word |
| in_tstamp | input | 14 | Timestamp for the pixel word |
| out_valid | output | 1 | `out_word` holds a frame word |
| out_word | output | 32 | Frame word, most significant first |
| enc_data | output | 270 | Scrambled payload for the parity encoder |
| enc_parity | input | 40 | Parity returned by the encoder |

## Verification
The bench feeds all-zero, all-one and mixed payloads, so the keystream appears bare in one frame and inverted in another. A wrong tap or a reversed bit order would therefore break every payload word. Frames are checked in sequence and again after a mid-run reset, which catches a scrambler that reseeds each frame or that fails to restart from its seed. An input is offered in the middle of a frame: a design that took it early would truncate the frame or overwrite the payload, and one that took it late would leave a gap before the chained frame. One scrambler copy is forced to a bad value across an acceptance, which would corrupt the payload if the vote were missing or miswired.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  localparam int unsigned LFSR_W = 7;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 7'h7F;

  // One step of the x^7+x^6+1 generator; new bit enters at the LSB.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
  endfunction
endpackage

// File: rtl/pfb_state_cell.sv
module pfb_state_cell #(
  parameter int unsigned W = 7,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= INIT;
    else        q <= d;
  end
endmodule

// File: rtl/pfb_vote.sv
module pfb_vote #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  assign y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/pfb_scrambler.sv
module pfb_scrambler
  import pfb_pkg::*;
#(
  parameter int unsigned PAY_W = 270,
  parameter int unsigned COPIES = 3,
  parameter logic [LFSR_W-1:0] SEED = LFSR_SEED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [PAY_W-1:0] raw,
  output logic [PAY_W-1:0] scr
);
  logic [LFSR_W-1:0] copy_q [COPIES];
  logic [LFSR_W-1:0] voted;
  logic [LFSR_W-1:0] end_state;
  logic [LFSR_W-1:0] next_state;

  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    pfb_state_cell #(.W(LFSR_W), .INIT(SEED)) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (next_state),
      .q    (copy_q[g])
    );
  end

  pfb_vote #(.W(LFSR_W)) u_vote (
    .a(copy_q[0]),
    .b(copy_q[1]),
    .c(copy_q[2]),
    .y(voted)
  );

  // Unrolled keystream: first generated bit covers the payload MSB.
  always_comb begin
    logic [LFSR_W-1:0] s;
    s = voted;
    for (int i = PAY_W - 1; i >= 0; i--) begin
      s      = lfsr_step(s);
      scr[i] = raw[i] ^ s[0];
    end
    end_state = s;
  end

  // Every copy reloads the voted value each cycle, which scrubs upsets.
  assign next_state = advance ? end_state : voted;
endmodule

// File: rtl/pixel_frame_builder.sv
module pixel_frame_builder
  import pfb_pkg::*;
#(
  parameter int unsigned PIX_W  = 256,
  parameter int unsigned TS_W   = 14,
  parameter int unsigned PAR_W  = 40,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned HDR_W  = 10,
  parameter logic [HDR_W-1:0] HDR_PAT = 10'b1111100000,
  parameter logic [LFSR_W-1:0] SEED = LFSR_SEED
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [PIX_W-1:0]      in_pixels,
  input  logic [TS_W-1:0]       in_tstamp,
  output logic                  out_valid,
  output logic [WORD_W-1:0]     out_word,
  output logic [PIX_W+TS_W-1:0] enc_data,
  input  logic [PAR_W-1:0]      enc_parity
);
  localparam int unsigned PAY_W   = PIX_W + TS_W;
  localparam int unsigned FRAME_W = HDR_W + PAY_W + PAR_W;
  localparam int unsigned N_WORDS = FRAME_W / WORD_W;
  localparam int unsigned CNT_W   = $clog2(N_WORDS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_WORDS - 1);

  logic             accept;
  logic             busy;
  logic [CNT_W-1:0] idx;
  logic [PAY_W-1:0] pay_q;
  logic [PAY_W-1:0] pay_scr;
  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] frame_sh;

  assign in_ready = !busy || (idx == LAST);
  assign accept   = in_valid && in_ready;

  pfb_scrambler #(.PAY_W(PAY_W), .COPIES(3), .SEED(SEED)) u_scr (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(accept),
    .raw    ({in_pixels, in_tstamp}),
    .scr    (pay_scr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      pay_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      idx   <= '0;
      pay_q <= pay_scr;
    end else if (busy) begin
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign frame     = {HDR_PAT, pay_q, enc_parity};
  assign frame_sh  = frame << (WORD_W * idx);
  assign out_word  = frame_sh[FRAME_W-1 -: WORD_W];
  assign out_valid = busy;
  assign enc_data  = pay_q;
endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned HDR_W   = 10,
  parameter logic [HDR_W-1:0] HDR_PAT = 10'b1111100000,
  parameter int unsigned PAY_W   = 270,
  parameter int unsigned N_WORDS = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_word,
  input logic [PAY_W-1:0]  enc_data
);
  localparam logic [7:0] NW   = 8'(N_WORDS);
  localparam logic [7:0] LASTW = 8'(N_WORDS - 1);

  logic       acc;
  logic [7:0] wc;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)         wc <= '0;
    else if (acc)       wc <= '0;
    else if (out_valid) wc <= wc + 8'd1;
  end

  assert_first_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
  assert_word_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> wc < NW);
  assert_full_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(wc) == LASTW);
  assert_header_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_word[WORD_W-1 -: HDR_W] == HDR_PAT);
  assert_enc_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !acc) |=> $stable(enc_data));
  assert_hold_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wc < LASTW) |-> !in_ready);
  assert_idle_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  assert_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && out_valid) |=> out_valid);
endmodule

bind pixel_frame_builder pfb_checker #(
  .WORD_W (WORD_W),
  .HDR_W  (HDR_W),
  .HDR_PAT(HDR_PAT),
  .PAY_W  (PAY_W),
  .N_WORDS(N_WORDS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_word (out_word),
  .enc_data (enc_data)
);

// File: tb/pixel_frame_builder_bench.sv
module pixel_frame_builder_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_pixels = '0;
  logic [13:0]  in_tstamp = '0;
  logic         out_valid;
  logic [31:0]  out_word;
  logic [269:0] enc_data;
  logic [39:0]  enc_parity;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int run    = 0;
  int last_run = 0;
  logic [6:0] ms = 7'h7F;
  logic [31:0] exp_q [$];
  int          idx_q [$];

  always #2 clk = ~clk;

  // Stand-in parity encoder: XOR fold of the payload into 40 bits.
  function automatic logic [39:0] fold(input logic [269:0] p);
    logic [279:0] w;
    logic [39:0]  r;
    w = {10'b0, p};
    r = '0;
    for (int c = 0; c < 7; c++) r ^= w[c*40 +: 40];
    return r;
  endfunction

  assign enc_parity = fold(enc_data);

  pixel_frame_builder u_pixel_frame_builder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixels(in_pixels), .in_tstamp(in_tstamp), .out_valid(out_valid),
    .out_word(out_word), .enc_data(enc_data), .enc_parity(enc_parity)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: offers one input and pushes its expected ten words.
  task automatic send(input logic [255:0] pix, input logic [13:0] ts);
    logic [269:0] raw, pay;
    logic [319:0] fr;
    logic [6:0]   s;
    logic         k;
    in_pixels = pix;
    in_tstamp = ts;
    in_valid  = 1'b1;
    while (!in_ready) @(negedge clk);
    raw = {pix, ts};
    s = ms;
    for (int i = 269; i >= 0; i--) begin
      k = s[6] ^ s[5];
      pay[i] = raw[i] ^ k;
      s = {s[5:0], k};
    end
    ms = s;
    fr = {10'b1111100000, pay, fold(pay)};
    for (int w = 0; w < 10; w++) begin
      exp_q.push_back(fr[319 - 32*w -: 32]);
      idx_q.push_back(w);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: compares each produced word against the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        run++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected word", out_word, 32'h0);
        end else begin
          logic [31:0] e;
          int w;
          e = exp_q.pop_front();
          w = idx_q.pop_front();
          if (w == 0)
            check(out_word == e, "R3/R4 word0", out_word, e);
          else if (w >= 8)
            check(out_word == e, "R6 parity word", out_word, e);
          else
            check(out_word == e, "R4/R5 payload word", out_word, e);
        end
      end else if (run != 0) begin
        last_run = run;
        run = 0;
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'h0);
    check(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'h1);

    // R4 R5: all-zero payload exposes the bare keystream.
    send('0, '0);
    check(out_valid == 1'b1, "R2 first word timing", 32'(out_valid), 32'h1);
    check(out_word[31:22] == 10'b1111100000, "R3 header", 32'(out_word[31:22]), 32'h3E0);
    drain();
    check(last_run == 10, "R2 frame length", 32'(last_run), 32'd10);
    check(in_ready == 1'b1, "R7 idle ready", 32'(in_ready), 32'h1);

    send('1, '1);
    drain();
    send({8{32'hDEADBEEF}}, 14'h2A5A);
    drain();

    // R7 R8: input offered mid-frame is held, then chained.
    send({8{32'h12345678}}, 14'h0F0F);
    check(in_ready == 1'b0, "R7 busy not ready", 32'(in_ready), 32'h0);
    send({8{32'hA5A55A5A}}, 14'h3001);
    drain();
    check(last_run == 20, "R8 back-to-back run", 32'(last_run), 32'd20);

    // R9: one scrambler copy corrupted across an acceptance.
    force u_pixel_frame_builder.u_scr.g_copy[1].u_cell.q = 7'h00;
    send({8{32'h0BADF00D}}, 14'h1111);
    release u_pixel_frame_builder.u_scr.g_copy[1].u_cell.q;
    drain();
    send({8{32'hCAFEBABE}}, 14'h2222);
    drain();
    check(last_run == 10, "R9 frame after upset", 32'(last_run), 32'd10);

    // R5: reset restarts the keystream from the seed.
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    exp_q.delete();
    idx_q.delete();
    run = 0;
    ms = 7'h7F;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 after reset", 32'(out_valid), 32'h0);
    send({8{32'h13579BDF}}, 14'h0ACE);
    drain();
    check(exp_q.size() == 0, "R5 all words seen", 32'(exp_q.size()), 32'h0);

    finish_run();
  end
endmodule